// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block generates the word address stream for a synchronous burst read. A load strobe captures a start address and a 2-bit burst mode. After that, each advance strobe moves the address pointer on by one word. The current pointer is driven out as the word address.

In continuous mode the pointer walks linearly through the whole address space. Past the top address it rolls over to zero. The three wrap modes keep the pointer inside an aligned group of 8, 16 or 32 words. Only the low bits of the address count within the group. The bits above the group stay fixed, so a wrapping burst never leaves its 64-word block. A new load always restarts the sequence, even in the middle of a burst. Latency, data and command decoding are handled elsewhere.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the word address is zero and the mode is continuous.
- R2: A clock edge with loadIn high sets wordAddr to startAddr and latches modeIn. The new address is visible after that edge.
- R3: On an edge with both loadIn and advIn low, wordAddr and the latched mode are unchanged.
- R4: In continuous mode (code 00), an edge with advIn high and loadIn low raises wordAddr by exactly one.
- R5: In continuous mode, advancing from the all-ones address gives address zero.
- R6: In 8-word wrap mode (code 01), an advance increments bits [2:0] modulo 8. All higher bits stay unchanged.
- R7: In 16-word wrap mode (code 10), an advance increments bits [3:0] modulo 16. All higher bits stay unchanged.
- R8: In 32-word wrap mode (code 11), an advance increments bits [4:0] modulo 32. All higher bits stay unchanged.
- R9: In any wrap mode, address bits [ADDR_W-1:6] never change on an advance, so the burst never crosses a 64-word boundary.
- R10: loadIn takes priority over advIn on the same edge. A load during a running burst aborts it and restarts from the new start address and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadIn | input | 1 | Captures startAddr and modeIn |
| startAddr | input | ADDR_W | Start word address of the burst |
| modeIn | input | 2 | Burst mode: 00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32 |
| advIn | input | 1 | Advances the pointer by one word |
| wordAddr | output | ADDR_W | Current word address |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The address register is the only stage between the strobes and wordAddr. The bench drives the strobes on the falling edge and lets one rising edge pass. It then compares wordAddr on the following falling edge against a bench model stepped by the same rule. Each compare therefore sees the effect of exactly the one edge just taken, whether that edge carried a load, an advance or neither.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_WRAP8  = 2'b01,
    MODE_WRAP16 = 2'b10,
    MODE_WRAP32 = 2'b11
  } burstMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadStb;   // take the start address
    logic       stepStb;   // advance by one word
    logic       wrapEn;    // confine the count to a group
    logic [2:0] lowBits;   // log2 of group size when wrapEn
  } seqCtl_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadIn,
  input  logic [1:0] modeIn,
  input  logic       advIn,
  output seqCtl_t    ctl
);

  burstMode_t modeQ;

  always_ff @(posedge clk) begin
    if (rst)         modeQ <= MODE_CONT;
    else if (loadIn) modeQ <= burstMode_t'(modeIn);
  end

  always_comb begin
    ctl.loadStb = loadIn;
    ctl.stepStb = advIn & ~loadIn;
    ctl.wrapEn  = (modeQ != MODE_CONT);
    case (modeQ)
      MODE_WRAP8:  ctl.lowBits = 3'd3;
      MODE_WRAP16: ctl.lowBits = 3'd4;
      MODE_WRAP32: ctl.lowBits = 3'd5;
      default:     ctl.lowBits = 3'd0;
    endcase
  end

  // R2 / R10: mode taken from the load edge
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    loadIn |=> (modeQ == burstMode_t'($past(modeIn))));

  // R3: mode holds without a load
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !loadIn |=> $stable(modeQ));

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam int BLOCK_BITS = 6;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] countMask;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;

  // Per-bit count mask: all bits in continuous mode, low bits in wrap modes
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign countMask[b] = !ctl.wrapEn || (b < int'(ctl.lowBits));
  end

  assign incAddr = addrQ + 1'b1;

  always_comb begin
    nextAddr = addrQ;
    if (ctl.loadStb)      nextAddr = startAddr;
    else if (ctl.stepStb) nextAddr = (addrQ & ~countMask) | (incAddr & countMask);
  end

  always_ff @(posedge clk) begin
    if (rst) addrQ <= '0;
    else     addrQ <= nextAddr;
  end

  assign wordAddr = addrQ;

  // R2: load lands on the next edge
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.loadStb |=> (addrQ == $past(startAddr)));

  // R3: no strobe, no move
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadStb && !ctl.stepStb) |=> $stable(addrQ));

  // R4: continuous step is plus one
  assert_cont_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepStb && !ctl.wrapEn) |=> (addrQ == $past(addrQ) + 1'b1));

  // R5: rollover from the top
  assert_cont_roll_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepStb && !ctl.wrapEn && addrQ == ALL_ONES) |=> (addrQ == '0));

  // R6, R7, R8: bits above the group stay fixed
  assert_wrap_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.stepStb && ctl.wrapEn) |=>
      ((addrQ >> $past(ctl.lowBits)) == ($past(addrQ) >> $past(ctl.lowBits))));

  if (ADDR_W > BLOCK_BITS) begin : g_block_chk
    // R9: the 64-word block never changes in a wrap mode
    assert_no_block_cross_R9: assert property (@(posedge clk) disable iff (rst)
      (ctl.stepStb && ctl.wrapEn) |=>
        (addrQ[ADDR_W-1:BLOCK_BITS] == $past(addrQ[ADDR_W-1:BLOCK_BITS])));
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadIn,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        modeIn,
  input  logic              advIn,
  output logic [ADDR_W-1:0] wordAddr
);

  seqCtl_t ctl;

  burst_seq_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .loadIn (loadIn),
    .modeIn (modeIn),
    .advIn  (advIn),
    .ctl    (ctl)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .startAddr (startAddr),
    .wordAddr  (wordAddr)
  );

  // R10: load and advance together act as a load
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (loadIn && advIn) |=> (wordAddr == $past(startAddr)));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

  localparam int AW = 22;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst;
  logic          loadIn;
  logic [AW-1:0] startAddr;
  logic [1:0]    modeIn;
  logic          advIn;
  logic [AW-1:0] wordAddr;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  logic [AW-1:0] expAddr;
  logic [1:0]    expMode;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .loadIn(loadIn), .startAddr(startAddr),
    .modeIn(modeIn), .advIn(advIn), .wordAddr(wordAddr)
  );

  function automatic logic [AW-1:0] stepAddr(logic [AW-1:0] a, logic [1:0] m);
    logic [AW-1:0] msk;
    if (m == 2'b00) return a + 1'b1;
    msk = (AW'(1) << (int'(m) + 2)) - 1'b1;
    return (a & ~msk) | ((a + 1'b1) & msk);
  endfunction

  function automatic string tagOf(bit ld, bit adv, logic [1:0] m);
    if (ld) return "R2";
    if (!adv) return "R3";
    case (m)
      2'b00: return "R4";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: wordAddr got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, compare at next falling edge
  task automatic cyc(bit ld, logic [AW-1:0] st, logic [1:0] md, bit adv, string tag);
    loadIn = ld; startAddr = st; modeIn = md; advIn = adv;
    @(posedge clk);
    if (ld) begin expAddr = st; expMode = md; end
    else if (adv) expAddr = stepAddr(expAddr, expMode);
    @(negedge clk);
    check(tag == "" ? tagOf(ld, adv, expMode) : tag, wordAddr, expAddr);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] blk;
    void'($urandom(32'd1234));
    rst = 1'b1; loadIn = 0; startAddr = '0; modeIn = 0; advIn = 0;
    expAddr = '0; expMode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", wordAddr, '0);
    rst = 1'b0;
    // R1: mode after reset is continuous, so an advance adds one
    cyc(0, '0, 2'b00, 1, "R1");
    cyc(0, '0, 2'b00, 0, "R3");

    // R5: continuous rollover from the top
    cyc(1, TOP - 1, 2'b00, 0, "R2");
    cyc(0, '0, 2'b00, 1, "R4");
    cyc(0, '0, 2'b00, 1, "R5");
    check("R5", wordAddr, '0);
    cyc(0, '0, 2'b00, 1, "R4");

    // R6: 8-word wrap from an odd start inside a group
    cyc(1, 22'h12345, 2'b01, 0, "R2");
    for (int i = 0; i < 9; i++) cyc(0, '0, 2'b00, 1, "R6");
    check("R6", wordAddr, 22'h12346);

    // R7 and R9: 16-word wrap at the top of a 64-word block
    cyc(1, 22'h0ABFF, 2'b10, 0, "R2");
    cyc(0, '0, 2'b00, 1, "R7");
    check("R9", wordAddr, 22'h0ABF0);
    for (int i = 0; i < 15; i++) cyc(0, '0, 2'b00, 1, "R7");
    check("R7", wordAddr, 22'h0ABFF);

    // R8 and R9: 32-word wrap crossing bit 5
    cyc(1, 22'h3FFFFF, 2'b11, 0, "R2");
    cyc(0, '0, 2'b00, 1, "R8");
    check("R9", wordAddr, 22'h3FFFE0);

    // R10: load with advance on the same edge, then mid-burst abort
    cyc(1, 22'h00107, 2'b01, 1, "R10");
    check("R10", wordAddr, 22'h00107);
    cyc(0, '0, 2'b00, 1, "R6");
    cyc(0, '0, 2'b00, 1, "R6");
    cyc(1, 22'h2000A, 2'b00, 1, "R10");
    cyc(0, '0, 2'b00, 1, "R4");
    check("R10", wordAddr, 22'h2000B);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      bit ld, adv;
      logic [AW-1:0] st;
      ld  = ($urandom % 10) == 0;
      adv = ($urandom % 10) < 7;
      st  = AW'($urandom);
      if (($urandom % 8) == 0) st = TOP - AW'($urandom % 4);
      blk = expAddr;
      cyc(ld, st, 2'($urandom), adv, "");
      if (!ld && adv && expMode != 2'b00)
        check("R9", {wordAddr[AW-1:6], 6'd0}, {blk[AW-1:6], 6'd0});
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule